// File: doc/BRIEF.md
# Broadcast-Operand Saturating Vector ALU

This block is a single-issue vector arithmetic and logic unit that works on eight 16-bit lanes packed into 128-bit words. Each operation takes a function code, a first operand, a second operand and a 4-bit element code. The element code steers which lanes of the second operand feed each result lane. It can pass the lanes straight through, repeat one half of the vector, repeat one pair of lanes, or copy one lane to all eight. The routed operand then goes to a per-lane datapath. That datapath offers signed saturating addition, signed saturating subtraction that consumes a per-lane borrow bit, wrapping subtraction that produces those borrow bits, and six bitwise functions.

A 16-bit flag register holds one borrow bit per lane in its low eight bits. The upper eight bits always read zero. A wrapping subtraction writes the register. Both saturating operations read it, then clear it. The bitwise functions and unrecognised codes leave it alone.

Operations enter through a valid/ready handshake and leave through a one-entry output register that has its own valid/ready handshake. A new operation is accepted only when the output register is empty or is being drained in the same cycle. While the consumer holds back its ready, the result and the flags stay frozen and the input side stalls. The flag update takes effect on the same clock edge that loads the result, so a following operation always sees the flags left by the operation before it.

Top module: `vec_sat_alu`

## Requirements
- R1: With element code 0 or 1, result lane i uses lane i of the second operand.
- R2: With element code 2, lane i uses second-operand lane (i mod 4); with code 3 it uses lane 4 + (i mod 4).
- R3: With element code 4, 5, 6 or 7 (call it k), lane i uses second-operand lane 2*(k-4) + (i mod 2).
- R4: With element code 8 through 15 (call it k), every lane uses second-operand lane k-8.
- R5: Function 0x10 yields the signed sum per lane, clamped to 0x7FFF above and to 0x8000 below.
- R6: Function 0x11 yields a - b - flag[i] per lane as signed values, clamped to 0x7FFF above and to 0x8000 below, where flag[i] is the flag bit of lane i before the operation.
- R7: Function 0x15 yields (a - b) mod 2^16 per lane without clamping, and sets flag bit i exactly when lane i's unsigned a is less than its unsigned routed b; flag bits 8..15 become zero.
- R8: After an accepted function 0x10 or 0x11, the flag register reads zero.
- R9: Functions 0x28 AND, 0x29 NAND, 0x2A OR, 0x2B NOR, 0x2C XOR and 0x2D XNOR apply per bit to the first operand and the routed second operand, and leave the flag register unchanged.
- R10: Any other function code yields an all-zero result and leaves the flag register unchanged.
- R11: An operation is accepted on a clock edge where in_valid and in_ready are both high, and its result appears on out_data with out_valid high after that edge. in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_data and flags_o hold.
- R12: During reset out_valid is low, in_ready is high and flags_o is zero.
- R13: Flag bits 8..15 are zero at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation this cycle |
| in_func | input | 6 | Function code |
| in_a | input | 128 | First operand, lane i at bits 16*i+15..16*i |
| in_b | input | 128 | Second operand before element routing |
| in_elem | input | 4 | Element routing code |
| out_valid | output | 1 | out_data holds an unconsumed result |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 128 | Result vector |
| flags_o | output | 16 | Per-lane borrow flags, bits 8..15 zero |

## Verification
The bench builds the block with its default 16-bit lanes. At that size it can cover the whole product of all 64 function codes and all 16 element codes. It also runs directed passes over every routing code with distinct lane values. Lane operands are drawn from a set weighted towards 0x7FFF, 0x8000, 0x0000, 0xFFFF, 0x0001 and 0x7FFE, so clamping in both directions comes up often. So does the extra borrow pushing a lane across the lower limit. The flag state carries from each operation to the next, and the bench follows it with its own arithmetic model. Stall, release and reset sequences check that the result and the flags hold at the handshake.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

  localparam int LANES = 8;
  localparam int SPECW = 4;
  localparam int FUNCW = 6;
  localparam int LIW   = $clog2(LANES);

  localparam logic [FUNCW-1:0] FN_ADD  = 6'h10;
  localparam logic [FUNCW-1:0] FN_SUB  = 6'h11;
  localparam logic [FUNCW-1:0] FN_SUBC = 6'h15;
  localparam logic [FUNCW-1:0] FN_AND  = 6'h28;
  localparam logic [FUNCW-1:0] FN_NAND = 6'h29;
  localparam logic [FUNCW-1:0] FN_OR   = 6'h2A;
  localparam logic [FUNCW-1:0] FN_NOR  = 6'h2B;
  localparam logic [FUNCW-1:0] FN_XOR  = 6'h2C;
  localparam logic [FUNCW-1:0] FN_XNOR = 6'h2D;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_SUB,
    OP_SUBC,
    OP_AND,
    OP_NAND,
    OP_OR,
    OP_NOR,
    OP_XOR,
    OP_XNOR
  } op_e;

  function automatic op_e decode_func(input logic [FUNCW-1:0] f);
    op_e o;
    case (f)
      FN_ADD:  o = OP_ADD;
      FN_SUB:  o = OP_SUB;
      FN_SUBC: o = OP_SUBC;
      FN_AND:  o = OP_AND;
      FN_NAND: o = OP_NAND;
      FN_OR:   o = OP_OR;
      FN_NOR:  o = OP_NOR;
      FN_XOR:  o = OP_XOR;
      FN_XNOR: o = OP_XNOR;
      default: o = OP_NONE;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/vsa_elem_route.sv
module vsa_elem_route
  import vsa_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [LANES*W-1:0] b_in,
  input  logic [SPECW-1:0]   sel,
  output logic [LANES*W-1:0] b_out
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LIW-1:0] LI = LIW'(i);
    logic [LIW-1:0] idx;

    // Code bits pick the granularity: bit 3 single lane, bit 2 pairs,
    // bit 1 halves, none set straight through.
    always_comb begin
      if (sel[3])      idx = sel[2:0];
      else if (sel[2]) idx = {sel[1:0], LI[0]};
      else if (sel[1]) idx = {sel[0], LI[1:0]};
      else             idx = LI;
    end

    assign b_out[i*W +: W] = b_in[idx*W +: W];
  end

endmodule

// File: rtl/vsa_lane.sv
module vsa_lane
  import vsa_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         borrow_in,
  output logic [W-1:0] res,
  output logic         borrow_out
);

  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] MINV = {3'b111, {(W-1){1'b0}}};
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic signed [XW-1:0] ax, bx, cx;
  logic signed [XW-1:0] sum_x, dif_x, pick_x;
  logic [W:0]           wrap_d;
  logic [W-1:0]         sat_v;

  assign ax = $signed({{2{a[W-1]}}, a});
  assign bx = $signed({{2{b[W-1]}}, b});
  assign cx = $signed({{(XW-1){1'b0}}, borrow_in});

  assign sum_x = ax + bx;
  assign dif_x = ax - bx - cx;
  assign pick_x = (op == OP_ADD) ? sum_x : dif_x;

  always_comb begin
    if (pick_x > MAXV)      sat_v = POS_LIM;
    else if (pick_x < MINV) sat_v = NEG_LIM;
    else                    sat_v = pick_x[W-1:0];
  end

  assign wrap_d     = {1'b0, a} - {1'b0, b};
  assign borrow_out = wrap_d[W];

  always_comb begin
    case (op)
      OP_ADD,
      OP_SUB:  res = sat_v;
      OP_SUBC: res = wrap_d[W-1:0];
      OP_AND:  res = a & b;
      OP_NAND: res = ~(a & b);
      OP_OR:   res = a | b;
      OP_NOR:  res = ~(a | b);
      OP_XOR:  res = a ^ b;
      OP_XNOR: res = ~(a ^ b);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/vsa_out_stage.sv
module vsa_out_stage #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  input  logic          take,
  output logic          valid,
  output logic          can_load,
  output logic [DW-1:0] q
);

  assign can_load = !valid || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vec_sat_alu.sv
module vec_sat_alu
  import vsa_pkg::*;
#(
  parameter int W     = 16,
  parameter int FLAGW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [FUNCW-1:0]     in_func,
  input  logic [LANES*W-1:0]   in_a,
  input  logic [LANES*W-1:0]   in_b,
  input  logic [SPECW-1:0]     in_elem,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LANES*W-1:0]   out_data,
  output logic [FLAGW-1:0]     flags_o
);

  localparam int DW = LANES * W;

  op_e              op;
  logic [DW-1:0]    b_routed;
  logic [DW-1:0]    res_vec;
  logic [LANES-1:0] brw_vec;
  logic [FLAGW-1:0] flags_q, flags_d;
  logic             accept;

  assign op     = decode_func(in_func);
  assign accept = in_valid && in_ready;

  vsa_elem_route #(.W(W)) u_route (
    .b_in  (in_b),
    .sel   (in_elem),
    .b_out (b_routed)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vsa_lane #(.W(W)) u_lane (
      .op         (op),
      .a          (in_a[i*W +: W]),
      .b          (b_routed[i*W +: W]),
      .borrow_in  (flags_q[i]),
      .res        (res_vec[i*W +: W]),
      .borrow_out (brw_vec[i])
    );
  end

  always_comb begin
    case (op)
      OP_ADD,
      OP_SUB:  flags_d = '0;
      OP_SUBC: flags_d = {{(FLAGW-LANES){1'b0}}, brw_vec};
      default: flags_d = flags_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (accept) flags_q <= flags_d;
  end

  vsa_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .d        (res_vec),
    .take     (out_ready),
    .valid    (out_valid),
    .can_load (in_ready),
    .q        (out_data)
  );

  assign flags_o = flags_q;

endmodule

// File: rtl/vsa_chk.sv
module vsa_chk #(
  parameter int W     = 16,
  parameter int FLAGW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [5:0]         in_func,
  input logic               out_valid,
  input logic               out_ready,
  input logic [8*W-1:0]     out_data,
  input logic [FLAGW-1:0]   flags_o
);

  // R11
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(flags_o)));

  // R8
  sat_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_func == 6'h10 || in_func == 6'h11)) |=> (flags_o == '0));

  // R9
  logic_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_func[5:3] == 3'b101 && in_func[2:1] != 2'b11)
      |=> $stable(flags_o));

  // R13
  upper_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[FLAGW-1:8] == '0);

endmodule

bind vec_sat_alu vsa_chk #(.W(W), .FLAGW(FLAGW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_func   (in_func),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .flags_o   (flags_o)
);

// File: tb/tb_vec_sat_alu.sv
`timescale 1ns/1ps
module tb_vec_sat_alu;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [5:0]   in_func = '0;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic [3:0]   in_elem = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic [15:0]  flags_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [15:0] mflags = '0;

  always #2 clk = ~clk;

  vec_sat_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_a(in_a), .in_b(in_b), .in_elem(in_elem),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .flags_o(flags_o)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int src_lane(input int i, input int e);
    if (e < 2)      return i;
    else if (e < 4) return (e - 2) * 4 + (i % 4);
    else if (e < 8) return (e - 4) * 2 + (i % 2);
    else            return e - 8;
  endfunction

  function automatic logic [127:0] model_res(input logic [5:0] f, input logic [127:0] a,
      input logic [127:0] b, input int e, input logic [15:0] fl);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] av, bv, o;
      int sa, sb, s;
      av = a[i*16 +: 16];
      bv = b[src_lane(i, e)*16 +: 16];
      sa = $signed(av);
      sb = $signed(bv);
      o = 16'h0;
      case (f)
        6'h10, 6'h11: begin
          s = (f == 6'h10) ? sa + sb : sa - sb - int'(fl[i]);
          if (s > 32767) s = 32767;
          if (s < -32768) s = -32768;
          o = s[15:0];
        end
        6'h15: begin
          s = int'(av) - int'(bv);
          o = s[15:0];
        end
        6'h28: o = av & bv;
        6'h29: o = ~(av & bv);
        6'h2A: o = av | bv;
        6'h2B: o = ~(av | bv);
        6'h2C: o = av ^ bv;
        6'h2D: o = ~(av ^ bv);
        default: o = 16'h0;
      endcase
      r[i*16 +: 16] = o;
    end
    return r;
  endfunction

  function automatic logic [15:0] model_flags(input logic [5:0] f, input logic [127:0] a,
      input logic [127:0] b, input int e, input logic [15:0] fl);
    logic [15:0] n;
    n = fl;
    if (f == 6'h10 || f == 6'h11) n = 16'h0;
    else if (f == 6'h15) begin
      n = 16'h0;
      for (int i = 0; i < 8; i++)
        n[i] = (a[i*16 +: 16] < b[src_lane(i, e)*16 +: 16]);
    end
    return n;
  endfunction

  function automatic string res_tag(input logic [5:0] f);
    case (f)
      6'h10: return "R5";
      6'h11: return "R6";
      6'h15: return "R7";
      6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2C, 6'h2D: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic string flag_tag(input logic [5:0] f);
    case (f)
      6'h10, 6'h11: return "R8";
      6'h15: return "R7";
      6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2C, 6'h2D: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic string route_tag(input int e);
    if (e < 2) return "R1";
    else if (e < 4) return "R2";
    else if (e < 8) return "R3";
    else return "R4";
  endfunction

  function automatic logic [15:0] pick_val();
    case ($urandom % 8)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'h0000;
      3: return 16'hFFFF;
      4: return 16'h0001;
      5: return 16'h7FFE;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [127:0] pick_vec();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = pick_val();
    return v;
  endfunction

  function automatic logic [127:0] splat(input logic [15:0] x);
    return {8{x}};
  endfunction

  task automatic run_op(input logic [5:0] f, input logic [127:0] a, input logic [127:0] b,
      input int e, input string tag);
    logic [127:0] er;
    logic [15:0]  ef;
    er = model_res(f, a, b, e, mflags);
    ef = model_flags(f, a, b, e, mflags);
    @(negedge clk);
    in_func = f; in_a = a; in_b = b; in_elem = 4'(e); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 out_valid", {127'b0, out_valid}, 128'd1);
    chk(tag, out_data, er);
    chk((f == 6'h10 || f == 6'h11 || f == 6'h15 || res_tag(f) == "R9" || res_tag(f) == "R10")
        ? flag_tag(f) : "R10", {112'b0, flags_o}, {112'b0, ef});
    mflags = ef;
  endtask

  initial begin
    logic [127:0] distinct, va, vb, exp_a;
    logic [15:0]  fl_a;
    for (int i = 0; i < 8; i++) distinct[i*16 +: 16] = 16'(16'h1000 + i * 16'h0111);

    // R12: reset state
    #1;
    chk("R12 out_valid", {127'b0, out_valid}, 128'd0);
    chk("R12 in_ready", {127'b0, in_ready}, 128'd1);
    chk("R12 flags", {112'b0, flags_o}, 128'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1..R4: routing with OR against zero exposes the routed operand
    for (int e = 0; e < 16; e++) run_op(6'h2A, '0, distinct, e, route_tag(e));

    // R5: clamping both ways and an ordinary sum
    run_op(6'h10, splat(16'h7000), splat(16'h7000), 0, "R5 pos clamp");
    run_op(6'h10, splat(16'h8000), splat(16'hFFFF), 0, "R5 neg clamp");
    run_op(6'h10, splat(16'h0003), splat(16'h0004), 0, "R5 plain");

    // R7: wrap and borrow in alternate lanes
    va = {4{16'h0005, 16'h0001}};
    vb = splat(16'h0002);
    run_op(6'h15, va, vb, 0, "R7 wrap");
    // R9 / R10: flags survive logic and unknown codes
    run_op(6'h28, distinct, splat(16'h0FF0), 0, "R9 and keeps flags");
    run_op(6'h3F, distinct, distinct, 0, "R10 unknown");
    // R6: extra borrow in flagged lanes, clamp at the bottom
    run_op(6'h11, {4{16'h8000, 16'h0005}}, splat(16'h0002), 0, "R6 borrow");
    // R8: flags cleared by the saturating subtract above
    chk("R8 cleared", {112'b0, flags_o}, 128'd0);

    // R11: back-pressure holds data and flags, stalls input
    @(negedge clk);
    out_ready = 1'b0;
    va = pick_vec(); vb = pick_vec();
    exp_a = model_res(6'h15, va, vb, 5, mflags);
    fl_a  = model_flags(6'h15, va, vb, 5, mflags);
    in_func = 6'h15; in_a = va; in_b = vb; in_elem = 4'd5; in_valid = 1'b1;
    @(negedge clk);
    mflags = fl_a;
    in_func = 6'h10; in_a = splat(16'h0001); in_b = splat(16'h0001); in_elem = 4'd0;
    for (int k = 0; k < 3; k++) begin
      chk("R11 stall in_ready", {127'b0, in_ready}, 128'd0);
      chk("R11 stall data", out_data, exp_a);
      chk("R11 stall flags", {112'b0, flags_o}, {112'b0, fl_a});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 release data", out_data, splat(16'h0002));
    chk("R11 release flags", {112'b0, flags_o}, 128'd0);
    mflags = 16'h0;

    // Full sweep: all function codes by all element codes
    for (int f = 0; f < 64; f++)
      for (int e = 0; e < 16; e++)
        run_op(6'(f), pick_vec(), pick_vec(), e, res_tag(6'(f)));

    // R12: reset again after flags are set
    run_op(6'h15, splat(16'h0000), splat(16'h0001), 0, "R7 set before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 flags after reset", {112'b0, flags_o}, 128'd0);
    chk("R12 out_valid after reset", {127'b0, out_valid}, 128'd0);
    summary();
  end

endmodule